// File: doc/BRIEF.md
# Real-time clock control and status register bank

This block holds the four control and status registers of a bus-accessed real-time clock at addresses 0x0A through 0x0D. It decodes a three-bit oscillator field into oscillator-run and divider-enable outputs. A one-second strobe from the timekeeping core starts an update sequence, and the block raises an update-in-progress status flag for a fixed number of cycles before it emits the update pulse. Writing the trimmed-start code 010 holds off the first update for a parameterized number of base ticks, which models the half-second delay.

The block also keeps the periodic, alarm and update event flags with their enables, and it combines them into an interrupt-request bit and an active-low interrupt pin. A rate field divides a base tick by a power of two to raise the periodic flag. A write-protect input blocks all bus writes. A backup-energy input is shown in the last register. Reads are combinational and available at any time, and a read of the flag register clears the flags.

Top module: `rtc_ctl_regs`

## Requirements
- R1: Register 0x0A holds the oscillator field in bits 6:4 and the rate field in bits 3:0, and both read back as written. Bit 7 ignores writes and reads the update-in-progress flag.
- R2: `osc_on` is 1 when the oscillator field is 010, 011, 110 or 111. `div_on` is 1 only when the field is 010 or 011.
- R3: A write of 010 to the oscillator field blocks one-second strobes until FIRST_TICKS base ticks have arrived. The update sequence then starts by itself on the tick that completes that count.
- R4: When the divider is enabled and no update is in progress, a strobe sets the update-in-progress flag for UIP_CYC cycles. `upd_go` pulses in the last of those cycles, and the flag clears at the same edge that records the update.
- R5: While the transfer-inhibit bit (0x0B bit 7) is 1, bit 7 of 0x0B... reads of 0x0A bit 7 return 0. The update sequence and `upd_go` are unaffected.
- R6: Register 0x0B holds transfer-inhibit (bit 7), the periodic, alarm and update interrupt enables (bits 6, 5 and 4), a reserved bit 3 that always reads 0, and three format bits (bits 2:0). Reset clears the three enables.
- R7: Register 0x0C reads the interrupt-request bit, then the periodic, alarm and update flags in bits 7:4, with 0 in bits 3:0. A read clears the flags, and an event that arrives in the same cycle as the clearing read is kept. Reset clears the flags.
- R8: The interrupt-request bit is 1 when any flag is set together with its enable. `irq_n` is its inverse.
- R9: A rate value of 0 never sets the periodic flag. A value k from 1 to 15 sets it on every 2^(k-1)-th base tick, counted from the last accepted write to 0x0A, and only while the divider is enabled.
- R10: Register 0x0D reads the `batt_ok` input in bit 7 and 0 in bits 6:0. Unmapped addresses read 0.
- R11: All bus writes are ignored while `wp` is 1.
- R12: `alarm_hit` sets the alarm flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (used for clear-on-read) |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| wp | input | 1 | Write-protect |
| base_tick | input | 1 | Base tick for periodic rate and holdoff |
| sec_strobe | input | 1 | One-second update request from timekeeping core |
| alarm_hit | input | 1 | Alarm match event |
| batt_ok | input | 1 | Backup energy valid |
| osc_on | output | 1 | Oscillator run |
| div_on | output | 1 | Divider enable |
| upd_go | output | 1 | Update pulse to timekeeping core |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A flag can be set by an event and cleared by a read of 0x0C in the same cycle. The bench provokes this by raising `alarm_hit` during the clearing read, both in a directed case and at random times. The read must return the old flag values, and the next read must show the alarm flag set. A second overlap happens when transfer-inhibit is active during an update. In that case the status bit must read 0 while `upd_go` still pulses once.

// File: rtl/rtc_ctl_pkg.sv
package rtc_ctl_pkg;
   localparam logic [2:0] OSC_TRIM_START = 3'b010;

   typedef struct packed {
      logic pf;
      logic af;
      logic uf;
   } evt_flags_t;

   function automatic logic osc_running(input logic [2:0] f);
      return f[1];
   endfunction

   function automatic logic div_running(input logic [2:0] f);
      return f[2:1] == 2'b01;
   endfunction
endpackage

// File: rtl/rtc_ctl_osc.sv
module rtc_ctl_osc
   import rtc_ctl_pkg::*;
#(
   parameter int FIRST_TICKS = 512,
   parameter int UIP_CYC     = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] osc_field,
   input  logic       osc_wr,
   input  logic [2:0] osc_new,
   input  logic       base_tick,
   input  logic       sec_strobe,
   input  logic       uti,
   output logic       osc_on,
   output logic       div_on,
   output logic       uip,
   output logic       upd_go
);
   localparam int HOLD_W = $clog2(FIRST_TICKS + 1);
   localparam int BUSY_W = $clog2(UIP_CYC + 1);

   if (FIRST_TICKS < 2) begin : g_bad_hold
      $error("FIRST_TICKS must be at least 2");
   end
   if (UIP_CYC < 1) begin : g_bad_busy
      $error("UIP_CYC must be at least 1");
   end

   logic [HOLD_W-1:0] hold_q;
   logic [BUSY_W-1:0] busy_q;
   logic hold_act, hold_fire, start;

   assign osc_on    = osc_running(osc_field);
   assign div_on    = div_running(osc_field);
   assign hold_act  = hold_q != '0;
   assign hold_fire = base_tick && hold_q == HOLD_W'(1);
   assign start     = div_on && busy_q == '0 && (hold_fire || (sec_strobe && !hold_act));

   always_ff @(posedge clk) begin
      if (!rst_n)
         hold_q <= '0;
      else if (osc_wr)
         hold_q <= (osc_new == OSC_TRIM_START) ? HOLD_W'(FIRST_TICKS) : '0;
      else if (hold_act && base_tick)
         hold_q <= hold_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         busy_q <= '0;
      else if (start)
         busy_q <= BUSY_W'(UIP_CYC);
      else if (busy_q != '0)
         busy_q <= busy_q - 1'b1;
   end

   assign upd_go = busy_q == BUSY_W'(1);
   assign uip    = busy_q != '0 && !uti;

   a_r4_flag_ends_at_update: assert property (@(posedge clk) disable iff (!rst_n)
      upd_go |=> !uip);
   a_r3_holdoff_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q > HOLD_W'(1) && busy_q == '0) |=> busy_q == '0);
endmodule

// File: rtl/rtc_ctl_rate.sv
module rtc_ctl_rate #(
   parameter int RS_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RS_W-1:0] rs,
   input  logic            restart,
   input  logic            tick,
   output logic            per_hit
);
   localparam int PER_W = (1 << RS_W) - 2;

   logic [PER_W-1:0] cnt_q, mask;

   always_comb begin
      mask = '0;
      for (int i = 0; i < PER_W; i++)
         if (i + 1 < int'(rs)) mask[i] = 1'b1;
   end

   assign per_hit = tick && rs != '0 && (cnt_q & mask) == mask;

   always_ff @(posedge clk) begin
      if (!rst_n || restart)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= cnt_q + 1'b1;
   end

   a_r9_fastest_rate: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && rs == RS_W'(1)) |-> per_hit);
endmodule

// File: rtl/rtc_ctl_irq.sv
module rtc_ctl_irq
   import rtc_ctl_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  evt_flags_t set,
   input  logic       clr,
   input  evt_flags_t en,
   output evt_flags_t flags,
   output logic       irqf,
   output logic       irq_n
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         flags <= '0;
      else
         flags <= set | (clr ? evt_flags_t'('0) : flags);
   end

   assign irqf = |(flags & en);

   if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b1;
         else        irq_q <= ~irqf;
      end
      assign irq_n = irq_q;
   end else begin : g_comb
      assign irq_n = ~irqf;
   end

   a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      set.af |=> flags.af);
   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && set == '0) |=> flags == '0);
endmodule

// File: rtl/rtc_ctl_regs.sv
module rtc_ctl_regs
   import rtc_ctl_pkg::*;
#(
   parameter int             ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h0A,
   parameter int             FIRST_TICKS = 512,
   parameter int             UIP_CYC     = 8,
   parameter bit             IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic              wp,
   input  logic              base_tick,
   input  logic              sec_strobe,
   input  logic              alarm_hit,
   input  logic              batt_ok,
   output logic              osc_on,
   output logic              div_on,
   output logic              upd_go,
   output logic              irq_n
);
   localparam int RS_W = 4;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W too small");
   end

   logic hit_a, hit_b, hit_c, hit_d, wr_ok;
   assign hit_a = addr == BASE_ADDR;
   assign hit_b = addr == BASE_ADDR + ADDR_W'(1);
   assign hit_c = addr == BASE_ADDR + ADDR_W'(2);
   assign hit_d = addr == BASE_ADDR + ADDR_W'(3);
   assign wr_ok = wr_en && !wp;

   logic [2:0]      osc_q;
   logic [RS_W-1:0] rs_q;
   logic            uti_q, dfmt_q, hfmt_q, dse_q;
   evt_flags_t      en_q;

   always_ff @(posedge clk) begin
      if (wr_ok && hit_a) begin
         osc_q <= wdata[6:4];
         rs_q  <= wdata[3:0];
      end
      if (wr_ok && hit_b) begin
         uti_q  <= wdata[7];
         dfmt_q <= wdata[2];
         hfmt_q <= wdata[1];
         dse_q  <= wdata[0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= '0;
      else if (wr_ok && hit_b)
         en_q <= evt_flags_t'(wdata[6:4]);
   end

   logic uip, per_hit, irqf;
   evt_flags_t flags, set;

   rtc_ctl_osc #(.FIRST_TICKS(FIRST_TICKS), .UIP_CYC(UIP_CYC)) u_osc (
      .clk(clk), .rst_n(rst_n), .osc_field(osc_q), .osc_wr(wr_ok && hit_a),
      .osc_new(wdata[6:4]), .base_tick(base_tick), .sec_strobe(sec_strobe),
      .uti(uti_q), .osc_on(osc_on), .div_on(div_on), .uip(uip), .upd_go(upd_go));

   rtc_ctl_rate #(.RS_W(RS_W)) u_rate (
      .clk(clk), .rst_n(rst_n), .rs(rs_q), .restart(wr_ok && hit_a),
      .tick(base_tick && div_on), .per_hit(per_hit));

   assign set = '{pf: per_hit, af: alarm_hit, uf: upd_go};

   rtc_ctl_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .set(set), .clr(rd_en && hit_c),
      .en(en_q), .flags(flags), .irqf(irqf), .irq_n(irq_n));

   always_comb begin
      rdata = '0;
      if (hit_a)      rdata = {uip, osc_q, rs_q};
      else if (hit_b) rdata = {uti_q, en_q, 1'b0, dfmt_q, hfmt_q, dse_q};
      else if (hit_c) rdata = {irqf, flags, 4'b0};
      else if (hit_d) rdata = {batt_ok, 7'b0};
   end

   a_r5_inhibit_hides_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (uti_q && hit_a) |-> !rdata[7]);
   a_r11_protect_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (wp && wr_en) |=> $stable({osc_q, rs_q, uti_q, en_q, dfmt_q, hfmt_q, dse_q}));
   a_r10_status_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      hit_d |-> rdata[6:0] == 7'b0);
endmodule

// File: tb/rtc_ctl_regs_bench.sv
`timescale 1ns/1ps
module rtc_ctl_regs_bench;
   localparam int FT = 6;
   localparam int UC = 3;
   localparam logic [7:0] RA = 8'h0A, RB = 8'h0B, RC = 8'h0C, RD = 8'h0D;

   logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, wp = 0;
   logic base_tick = 0, sec_strobe = 0, alarm_hit = 0, batt_ok = 0;
   logic [7:0] addr = 0, wdata = 0, rdata;
   logic osc_on, div_on, upd_go, irq_n;
   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   rtc_ctl_regs #(.FIRST_TICKS(FT), .UIP_CYC(UC)) u_rtc_ctl_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .wp(wp), .base_tick(base_tick),
      .sec_strobe(sec_strobe), .alarm_hit(alarm_hit), .batt_ok(batt_ok),
      .osc_on(osc_on), .div_on(div_on), .upd_go(upd_go), .irq_n(irq_n));

   function automatic logic exp_osc(input logic [2:0] f); return f[1]; endfunction
   function automatic logic exp_div(input logic [2:0] f); return f == 3'b010 || f == 3'b011; endfunction
   function automatic logic [7:0] exp_b(input logic [7:0] d); return d & 8'hF7; endfunction
   function automatic logic [7:0] exp_c(input logic [7:0] b, input logic af);
      return {af & b[5], 1'b0, af, 1'b0, 4'b0};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d, input logic alm = 0);
      addr = a; rd_en = 1; alarm_hit = alm;
      #1 d = rdata;
      @(negedge clk); rd_en = 0; alarm_hit = 0;
   endtask

   task automatic tick();
      base_tick = 1; @(negedge clk); base_tick = 0;
   endtask

   task automatic strobe_watch(input string req, input int exp_uip, output int n_uip, output int n_go, output int go_at);
      addr = RA; sec_strobe = 1; @(negedge clk); sec_strobe = 0;
      n_uip = 0; n_go = 0; go_at = 0;
      for (int i = 1; i <= 6; i++) begin
         if (rdata[7]) n_uip++;
         if (upd_go) begin n_go++; go_at = i; end
         @(negedge clk);
      end
      check(req, n_uip, exp_uip);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d, bm;
      logic af;
      int nu, ng, ga;
      repeat (3) @(negedge clk);
      rst_n = 1; @(negedge clk);

      // R6 R7 R8 reset state
      rd(RB, d); check("R6 reset enables", d & 8'h78, 0);
      rd(RC, d); check("R7 reset flags", d, 0);
      check("R8 reset irq_n", irq_n, 1);

      // R10
      batt_ok = 1; rd(RD, d); check("R10 backup valid", d, 8'h80);
      batt_ok = 0; rd(RD, d); check("R10 backup invalid", d, 8'h00);
      rd(8'h0E, d); check("R10 unmapped high", d, 0);
      rd(8'h09, d); check("R10 unmapped low", d, 0);

      // R2 R1 oscillator decode and readback
      for (int f = 0; f < 8; f++) begin
         wr(RA, {1'b0, 3'(f), 4'(f + 5)});
         check("R2 osc_on", osc_on, exp_osc(3'(f)));
         check("R2 div_on", div_on, exp_div(3'(f)));
         rd(RA, d); check("R1 readback", d, {1'b0, 3'(f), 4'(f + 5)});
      end
      wr(RA, 8'hFF); rd(RA, d); check("R1 bit7 read-only", d, 8'h7F);

      // R9 periodic rate
      for (int k = 1; k <= 4; k++) begin
         wr(RA, 8'h30 | 8'(k));
         rd(RC, d);
         for (int t = 0; t < (1 << (k - 1)) - 1; t++) tick();
         rd(RC, d); check("R9 before period", d[6], 0);
         tick();
         rd(RC, d); check("R9 at period", d[6], 1);
      end
      wr(RA, 8'h30); rd(RC, d);
      repeat (20) tick();
      rd(RC, d); check("R9 rate zero silent", d[6], 0);
      wr(RA, 8'h61); rd(RC, d);
      repeat (5) tick();
      rd(RC, d); check("R9 divider off", d[6], 0);

      // R4 R8 update sequence
      wr(RA, 8'h30); wr(RB, 8'h10); rd(RC, d);
      strobe_watch("R4 flag length", UC, nu, ng, ga);
      check("R4 single pulse", ng, 1);
      check("R4 pulse in last flag cycle", ga, UC);
      check("R8 irq_n asserted", irq_n, 0);
      rd(RC, d); check("R7 update flag", d, 8'h90);
      check("R8 irq_n released", irq_n, 1);

      // R5 transfer inhibit
      wr(RB, 8'h90);
      strobe_watch("R5 flag hidden", 0, nu, ng, ga);
      check("R5 update still pulses", ng, 1);
      rd(RC, d); check("R5 update recorded", d, 8'h90);
      wr(RB, 8'h10);

      // R3 first-update holdoff
      wr(RA, 8'h20);
      strobe_watch("R3 strobe ignored", 0, nu, ng, ga);
      check("R3 no pulse", ng, 0);
      addr = RA;
      for (int t = 0; t < FT - 1; t++) tick();
      #1 check("R3 idle before last tick", rdata[7], 0);
      tick();
      #1 check("R3 starts on last tick", rdata[7], 1);
      repeat (UC + 1) @(negedge clk);
      rd(RC, d); check("R3 update done", d, 8'h90);

      // R11 write protect
      wp = 1; wr(RA, 8'h35); wr(RB, 8'hEF); wp = 0;
      rd(RA, d); check("R11 reg A kept", d, 8'h20);
      rd(RB, d); check("R11 reg B kept", d, 8'h10);

      // R7 R12 set beats clear
      rd(RC, d, 1'b1); check("R7 old value on read", d, 8'h00);
      rd(RC, d); check("R12 alarm kept", d, 8'h20);

      // random mix
      void'($urandom(32'd2024));
      wr(RA, 8'h60); wr(RB, 8'h00); rd(RC, d);
      bm = 0; af = 0;
      for (int it = 0; it < 300; it++) begin
         case ($urandom % 4)
            0: begin
               logic [7:0] v; logic p;
               v = 8'($urandom); p = ($urandom % 4) == 0;
               wp = p; wr(RB, v); wp = 0;
               if (!p) bm = exp_b(v);
            end
            1: begin rd(RB, d); check("R6 random readback", d, bm); end
            2: begin alarm_hit = 1; @(negedge clk); alarm_hit = 0; af = 1; end
            default: begin
               logic a2;
               a2 = $urandom % 2;
               rd(RC, d, a2); check("R7 random read", d, exp_c(bm, af));
               af = a2;
            end
         endcase
         check("R8 random irq_n", irq_n, !(af && bm[5]));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule